// File: doc/BRIEF.md
# Shared Bus Layer Retry Arbiter

This block controls one layer of a shared interconnect: a single set of wires that many source ports compete for. Each cycle it decides whether a transfer offered by one of the sources may use the layer. The layer then stays occupied for a programmable number of cycles. A source that finds the layer occupied is placed in an ordered waiting queue. It is called back later with a one-cycle retry pulse.

A destination may also turn a transfer down. The layer then notes which source was refused in a table indexed by destination. When that destination later signals readiness, the layer passes the retry on to the noted source. If the layer is idle at that moment, it reserves itself for that source.

The controller has three states: idle (code 0), busy (code 1) and retrying (code 2). It also reports an idle flag for drain logic and counts the cycles spent busy.

Top module: `bus_layer_arb`

## Requirements
- R1: During and after a synchronous reset, `layer_state` is 0 (idle) and `layer_idle` is 1. `src_retry`, `src_done`, `src_refused` and `busy_cycles` are all zero. The waiting queue and the peer table are empty.
- R2: In the idle state, if any sources request, the lowest-index requester makes the attempt. The layer then enters busy (code 1) for `busy_len` cycles, or for 1 cycle when `busy_len` is 0.
- R3: A requesting source that does not make the attempt is appended to the waiting queue. Several such sources in one cycle are appended in ascending index order. A source already in the queue is never added a second time.
- R4: When the busy time ends, the layer goes to idle if the queue is empty. Otherwise it enters retrying (code 2), and `src_retry` pulses for exactly one cycle for the source at the head of the queue.
- R5: In retrying, the signalled source makes its attempt if it requests in the first retrying cycle. If it does not, the layer goes busy anyway and the source stays at the head of the queue.
- R6: Source i targets destination `src_dst[i*DW +: DW]`. If `dst_ready` for that destination is 1, `src_done` pulses for the source. If it is 0, `src_refused` pulses and the source is recorded against that destination. A later `dst_retry` for that destination sends a one-cycle `src_retry` pulse to the recorded source and clears the entry; a repeated `dst_retry` then does nothing.
- R7: A forwarded destination retry that arrives while the layer is idle and no source is requesting puts the layer into retrying for the forwarded source.
- R8: An attempt by a source that was called back from the queue head removes it from the queue, whether the destination accepts the transfer or refuses it.
- R9: `layer_idle` is 1 exactly when the state is idle and the waiting queue is empty.
- R10: `busy_cycles` increases by one for every cycle in which the state is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Source i offers a transfer this cycle |
| src_dst | input | NUM_SRC*DW | Destination ID for each source, packed by source index |
| dst_ready | input | NUM_DST | Destination accepts a transfer offered this cycle |
| dst_retry | input | NUM_DST | Destination signals it can take a transfer again |
| busy_len | input | BUSY_W | Cycles the layer stays busy after an attempt |
| src_retry | output | NUM_SRC | One-cycle retry pulse per source |
| src_done | output | NUM_SRC | One-cycle pulse: the source's transfer was accepted |
| src_refused | output | NUM_SRC | One-cycle pulse: the source's transfer was refused by its destination |
| layer_state | output | 2 | 0 idle, 1 busy, 2 retrying |
| layer_idle | output | 1 | Idle with an empty queue |
| busy_cycles | output | OCC_W | Count of cycles spent busy |

## Verification
Every output is registered, so each one reflects the inputs of cycle k right after the edge that closes cycle k. The bench drives each cycle's stimulus on the falling edge and samples one time unit after the next rising edge. The retry pulse raised at the end of the busy time is visible in the first retrying cycle, so a responding source requests during that same cycle. A forwarded destination retry appears on the edge after `dst_retry` is sampled. The occupancy count lags the state by one edge, so the bench compares it with the number of busy cycles observed only after the layer has returned to idle.

// File: rtl/bus_layer_pkg.sv
`timescale 1ns/1ps
package bus_layer_pkg;
  typedef enum logic [1:0] {
    LS_IDLE  = 2'd0,
    LS_BUSY  = 2'd1,
    LS_RETRY = 2'd2
  } lstate_t;
endpackage

// File: rtl/wait_queue.sv
`timescale 1ns/1ps
module wait_queue #(
  parameter int NUM_SRC = 4,
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CW = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pop,
  input  logic [NUM_SRC-1:0] push_mask,
  output logic [CW-1:0]      count,
  output logic [CW-1:0]      nxt_count,
  output logic [SW-1:0]      nxt_head
);
  logic [SW-1:0]      q  [NUM_SRC];
  logic [SW-1:0]      nq [NUM_SRC];
  logic [NUM_SRC-1:0] member, nmember;
  logic [CW-1:0]      ncnt;

  always_comb begin
    nq      = q;
    ncnt    = count;
    nmember = member;
    if (pop && count != '0) begin
      nmember[q[0]] = 1'b0;
      for (int i = 0; i < NUM_SRC - 1; i++) nq[i] = q[i+1];
      ncnt = count - CW'(1);
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (push_mask[s] && !nmember[s]) begin
        for (int j = 0; j < NUM_SRC; j++)
          if (CW'(j) == ncnt) nq[j] = SW'(s);
        ncnt       = ncnt + CW'(1);
        nmember[s] = 1'b1;
      end
    end
  end

  assign nxt_count = ncnt;
  assign nxt_head  = nq[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      member <= '0;
      for (int i = 0; i < NUM_SRC; i++) q[i] <= '0;
    end else begin
      count  <= ncnt;
      member <= nmember;
      for (int i = 0; i < NUM_SRC; i++) q[i] <= nq[i];
    end
  end
endmodule

// File: rtl/peer_table.sv
`timescale 1ns/1ps
module peer_table #(
  parameter int NUM_SRC = 4,
  parameter int NUM_DST = 4,
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int DW = (NUM_DST > 1) ? $clog2(NUM_DST) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_dst,
  input  logic [SW-1:0]      wr_src,
  input  logic [NUM_DST-1:0] dretry,
  output logic [NUM_SRC-1:0] fwd_mask,
  output logic               fwd_any,
  output logic [SW-1:0]      fwd_src
);
  logic [NUM_DST-1:0] pv;
  logic [SW-1:0]      ps [NUM_DST];

  always_comb begin
    fwd_mask = '0;
    fwd_any  = 1'b0;
    fwd_src  = '0;
    for (int d = NUM_DST - 1; d >= 0; d--) begin
      if (dretry[d] && pv[d]) begin
        fwd_mask[ps[d]] = 1'b1;
        fwd_any         = 1'b1;
        fwd_src         = ps[d];
      end
    end
  end

  generate
    for (genvar d = 0; d < NUM_DST; d++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          pv[d] <= 1'b0;
          ps[d] <= '0;
        end else if (wr_en && wr_dst == DW'(d)) begin
          pv[d] <= 1'b1;
          ps[d] <= wr_src;
        end else if (dretry[d]) begin
          pv[d] <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/layer_ctrl.sv
`timescale 1ns/1ps
module layer_ctrl
  import bus_layer_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int NUM_DST = 4,
  parameter int BUSY_W  = 4,
  parameter int OCC_W   = 16,
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int DW = (NUM_DST > 1) ? $clog2(NUM_DST) : 1,
  localparam int CW = $clog2(NUM_SRC + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    req,
  input  logic [NUM_SRC*DW-1:0] req_dst,
  input  logic [NUM_DST-1:0]    dst_ready,
  input  logic [BUSY_W-1:0]     busy_len,
  input  logic [CW-1:0]         q_nxt_count,
  input  logic [SW-1:0]         q_nxt_head,
  input  logic [NUM_SRC-1:0]    fwd_mask,
  input  logic                  fwd_any,
  input  logic [SW-1:0]         fwd_src,
  output logic                  pop,
  output logic [NUM_SRC-1:0]    push_mask,
  output logic                  wr_en,
  output logic [DW-1:0]         wr_dst,
  output logic [SW-1:0]         wr_src,
  output lstate_t               state,
  output logic [NUM_SRC-1:0]    retry_o,
  output logic [NUM_SRC-1:0]    done_o,
  output logic [NUM_SRC-1:0]    refused_o,
  output logic [OCC_W-1:0]      busy_cycles
);
  lstate_t           nstate;
  logic [BUSY_W-1:0] cnt, ncnt, blen_eff;
  logic [SW-1:0]     rsrc, nrsrc, win;
  logic              rfromq, nrfromq, attempt, acc, call_head;
  logic [NUM_SRC-1:0] win_oh;

  assign blen_eff = (busy_len == '0) ? BUSY_W'(1) : busy_len;

  always_comb begin
    attempt = 1'b0;
    win     = '0;
    if (state == LS_IDLE) begin
      for (int i = NUM_SRC - 1; i >= 0; i--)
        if (req[i]) begin
          attempt = 1'b1;
          win     = SW'(i);
        end
    end else if (state == LS_RETRY && req[rsrc]) begin
      attempt = 1'b1;
      win     = rsrc;
    end
    win_oh = '0;
    if (attempt) win_oh[win] = 1'b1;
  end

  assign wr_dst    = req_dst[win*DW +: DW];
  assign acc       = dst_ready[wr_dst];
  assign wr_src    = win;
  assign wr_en     = attempt && !acc;
  assign pop       = attempt && state == LS_RETRY && rfromq;
  assign push_mask = req & ~win_oh;

  always_comb begin
    nstate    = state;
    ncnt      = cnt;
    nrsrc     = rsrc;
    nrfromq   = rfromq;
    call_head = 1'b0;
    case (state)
      LS_IDLE: begin
        if (attempt) begin
          nstate = LS_BUSY;
          ncnt   = blen_eff;
        end else if (fwd_any) begin
          nstate  = LS_RETRY;
          nrsrc   = fwd_src;
          nrfromq = 1'b0;
        end
      end
      LS_BUSY: begin
        if (cnt <= BUSY_W'(1)) begin
          if (q_nxt_count != '0) begin
            nstate    = LS_RETRY;
            nrsrc     = q_nxt_head;
            nrfromq   = 1'b1;
            call_head = 1'b1;
          end else begin
            nstate = LS_IDLE;
          end
        end else begin
          ncnt = cnt - BUSY_W'(1);
        end
      end
      default: begin
        nstate = LS_BUSY;
        ncnt   = blen_eff;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= LS_IDLE;
      cnt         <= '0;
      rsrc        <= '0;
      rfromq      <= 1'b0;
      retry_o     <= '0;
      done_o      <= '0;
      refused_o   <= '0;
      busy_cycles <= '0;
    end else begin
      state     <= nstate;
      cnt       <= ncnt;
      rsrc      <= nrsrc;
      rfromq    <= nrfromq;
      retry_o   <= fwd_mask | (call_head ? (NUM_SRC'(1) << q_nxt_head) : '0);
      done_o    <= acc ? win_oh : '0;
      refused_o <= acc ? '0 : win_oh;
      if (state == LS_BUSY) busy_cycles <= busy_cycles + OCC_W'(1);
    end
  end
endmodule

// File: rtl/bus_layer_arb.sv
`timescale 1ns/1ps
module bus_layer_arb #(
  parameter int NUM_SRC = 4,
  parameter int NUM_DST = 4,
  parameter int BUSY_W  = 4,
  parameter int OCC_W   = 16,
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int DW = (NUM_DST > 1) ? $clog2(NUM_DST) : 1,
  localparam int CW = $clog2(NUM_SRC + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    src_req,
  input  logic [NUM_SRC*DW-1:0] src_dst,
  input  logic [NUM_DST-1:0]    dst_ready,
  input  logic [NUM_DST-1:0]    dst_retry,
  input  logic [BUSY_W-1:0]     busy_len,
  output logic [NUM_SRC-1:0]    src_retry,
  output logic [NUM_SRC-1:0]    src_done,
  output logic [NUM_SRC-1:0]    src_refused,
  output logic [1:0]            layer_state,
  output logic                  layer_idle,
  output logic [OCC_W-1:0]      busy_cycles
);
  import bus_layer_pkg::*;

  logic               pop, wr_en, fwd_any;
  logic [NUM_SRC-1:0] push_mask, fwd_mask;
  logic [CW-1:0]      q_count, q_nxt_count;
  logic [SW-1:0]      q_nxt_head, wr_src, fwd_src;
  logic [DW-1:0]      wr_dst;
  lstate_t            st;

  wait_queue #(.NUM_SRC(NUM_SRC)) u_queue (
    .clk(clk), .rst(rst), .pop(pop), .push_mask(push_mask),
    .count(q_count), .nxt_count(q_nxt_count), .nxt_head(q_nxt_head)
  );

  peer_table #(.NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST)) u_peer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_dst(wr_dst), .wr_src(wr_src),
    .dretry(dst_retry), .fwd_mask(fwd_mask), .fwd_any(fwd_any), .fwd_src(fwd_src)
  );

  layer_ctrl #(.NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .BUSY_W(BUSY_W), .OCC_W(OCC_W)) u_ctrl (
    .clk(clk), .rst(rst), .req(src_req), .req_dst(src_dst), .dst_ready(dst_ready),
    .busy_len(busy_len), .q_nxt_count(q_nxt_count), .q_nxt_head(q_nxt_head),
    .fwd_mask(fwd_mask), .fwd_any(fwd_any), .fwd_src(fwd_src),
    .pop(pop), .push_mask(push_mask), .wr_en(wr_en), .wr_dst(wr_dst), .wr_src(wr_src),
    .state(st), .retry_o(src_retry), .done_o(src_done), .refused_o(src_refused),
    .busy_cycles(busy_cycles)
  );

  assign layer_state = st;
  assign layer_idle  = (st == LS_IDLE) && (q_count == '0);
endmodule

// File: rtl/bus_layer_arb_chk.sv
`timescale 1ns/1ps
module bus_layer_arb_chk #(
  parameter int NUM_SRC = 4,
  parameter int OCC_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         layer_state,
  input logic               layer_idle,
  input logic [NUM_SRC-1:0] src_retry,
  input logic [NUM_SRC-1:0] src_done,
  input logic [NUM_SRC-1:0] src_refused,
  input logic [OCC_W-1:0]   busy_cycles
);
  a_r1_legal_state: assert property (@(posedge clk) disable iff (rst)
    layer_state != 2'd3);

  a_r2_single_winner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_done | src_refused));

  a_r2_attempt_busy: assert property (@(posedge clk) disable iff (rst)
    (src_done | src_refused) != '0 |-> layer_state == 2'd1);

  a_r4_head_called: assert property (@(posedge clk) disable iff (rst)
    (layer_state == 2'd2 && $past(layer_state) == 2'd1) |-> src_retry != '0);

  a_r5_retry_one_cycle: assert property (@(posedge clk) disable iff (rst)
    layer_state == 2'd2 |=> layer_state == 2'd1);

  a_r9_busy_not_idle: assert property (@(posedge clk) disable iff (rst)
    layer_state != 2'd0 |-> !layer_idle);

  a_r10_occupancy: assert property (@(posedge clk) disable iff (rst)
    layer_state == 2'd1 |=> busy_cycles == OCC_W'($past(busy_cycles) + 1'b1));
endmodule

bind bus_layer_arb bus_layer_arb_chk #(.NUM_SRC(NUM_SRC), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst(rst), .layer_state(layer_state), .layer_idle(layer_idle),
  .src_retry(src_retry), .src_done(src_done), .src_refused(src_refused),
  .busy_cycles(busy_cycles)
);

// File: tb/tb_bus_layer_arb.sv
`timescale 1ns/1ps
module tb_bus_layer_arb;
  localparam int NS = 4, ND = 4, BW = 4, OW = 16, DW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [NS-1:0]    src_req = '0;
  logic [NS*DW-1:0] src_dst = 8'b11_10_01_00;
  logic [ND-1:0]    dst_ready = '1, dst_retry = '0;
  logic [BW-1:0]    busy_len = 4'd2;
  logic [NS-1:0]    src_retry, src_done, src_refused;
  logic [1:0]       layer_state;
  logic             layer_idle;
  logic [OW-1:0]    busy_cycles;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bus_layer_arb #(.NUM_SRC(NS), .NUM_DST(ND), .BUSY_W(BW), .OCC_W(OW)) dut (
    .clk(clk), .rst(rst), .src_req(src_req), .src_dst(src_dst), .dst_ready(dst_ready),
    .dst_retry(dst_retry), .busy_len(busy_len), .src_retry(src_retry), .src_done(src_done),
    .src_refused(src_refused), .layer_state(layer_state), .layer_idle(layer_idle),
    .busy_cycles(busy_cycles)
  );

  // Row: req, ready, dst_retry | state, retry, done, refused, idle (source i targets destination i)
  // R3: rows 1, 14, 15, 19 queue refused sources, no duplicate at row 15.
  // R5: row 6 is an unanswered retry. R7: row 12. R8: rows 3, 9, 16, 22 pop the head.
  localparam int NV = 25;
  localparam logic [26:0] VEC [NV] = '{
    {4'b0001,4'b1111,4'b0000, 2'd1,4'b0000,4'b0001,4'b0000,1'b0},
    {4'b0110,4'b1111,4'b0000, 2'd1,4'b0000,4'b0000,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd2,4'b0010,4'b0000,4'b0000,1'b0},
    {4'b0010,4'b1111,4'b0000, 2'd1,4'b0000,4'b0010,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd1,4'b0000,4'b0000,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd2,4'b0100,4'b0000,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd1,4'b0000,4'b0000,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd1,4'b0000,4'b0000,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd2,4'b0100,4'b0000,4'b0000,1'b0},
    {4'b0100,4'b1011,4'b0000, 2'd1,4'b0000,4'b0000,4'b0100,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd1,4'b0000,4'b0000,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd0,4'b0000,4'b0000,4'b0000,1'b1},
    {4'b0000,4'b1111,4'b0100, 2'd2,4'b0100,4'b0000,4'b0000,1'b0},
    {4'b0100,4'b1111,4'b0000, 2'd1,4'b0000,4'b0100,4'b0000,1'b0},
    {4'b1000,4'b1111,4'b0000, 2'd1,4'b0000,4'b0000,4'b0000,1'b0},
    {4'b1000,4'b1111,4'b0000, 2'd2,4'b1000,4'b0000,4'b0000,1'b0},
    {4'b1000,4'b1111,4'b0000, 2'd1,4'b0000,4'b1000,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd1,4'b0000,4'b0000,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd0,4'b0000,4'b0000,4'b0000,1'b1},
    {4'b1010,4'b1111,4'b0000, 2'd1,4'b0000,4'b0010,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd1,4'b0000,4'b0000,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd2,4'b1000,4'b0000,4'b0000,1'b0},
    {4'b1000,4'b1111,4'b0000, 2'd1,4'b0000,4'b1000,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd1,4'b0000,4'b0000,4'b0000,1'b0},
    {4'b0000,4'b1111,4'b0000, 2'd0,4'b0000,4'b0000,4'b0000,1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] rq, input logic [3:0] rdy, input logic [3:0] dr);
    @(negedge clk);
    src_req = rq; dst_ready = rdy; dst_retry = dr;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_all(input string ctx, input logic [1:0] st, input logic [3:0] ro,
                         input logic [3:0] dn, input logic [3:0] rf, input logic id);
    chk({ctx, " R4 state"}, 32'(layer_state), 32'(st));
    chk({ctx, " R4 retry"}, 32'(src_retry), 32'(ro));
    chk({ctx, " R6 done"}, 32'(src_done), 32'(dn));
    chk({ctx, " R6 refused"}, 32'(src_refused), 32'(rf));
    chk({ctx, " R9 idle"}, 32'(layer_idle), 32'(id));
  endtask

  initial begin
    int nbusy;
    nbusy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    chk_all("R1 reset", 2'd0, 4'b0, 4'b0, 4'b0, 1'b1);
    chk("R1 busy_cycles", 32'(busy_cycles), 32'd0);

    // R2, R3, R4, R5, R6, R7, R8: scenario table
    for (int k = 0; k < NV; k++) begin
      step(VEC[k][26:23], VEC[k][22:19], VEC[k][18:15]);
      chk_all($sformatf("row%0d", k), VEC[k][14:13], VEC[k][12:9], VEC[k][8:5],
              VEC[k][4:1], VEC[k][0]);
      if (VEC[k][14:13] == 2'd1) nbusy++;
    end
    // R10: one count per busy cycle
    chk("R10 busy_cycles", 32'(busy_cycles), 32'(nbusy));

    // R2: busy_len 0 gives a single busy cycle; R6: destination refuses
    busy_len = 4'd0;
    step(4'b0001, 4'b1110, 4'b0000);
    chk("R2 len0 state", 32'(layer_state), 32'd1);
    chk("R6 refused s0", 32'(src_refused), 32'b0001);
    // R6: retry forwarded while busy, layer then idle
    step(4'b0000, 4'b1111, 4'b0001);
    chk("R2 len0 end", 32'(layer_state), 32'd0);
    chk("R6 forward busy", 32'(src_retry), 32'b0001);
    // R6: entry cleared, second retry does nothing
    step(4'b0000, 4'b1111, 4'b0001);
    chk("R6 cleared retry", 32'(src_retry), 32'b0000);
    chk("R7 no forward state", 32'(layer_state), 32'd0);

    // R1: reset in the middle of busy
    busy_len = 4'd3;
    step(4'b0001, 4'b1111, 4'b0000);
    chk("R2 busy before reset", 32'(layer_state), 32'd1);
    @(negedge clk); src_req = '0; rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk_all("R1 midreset", 2'd0, 4'b0, 4'b0, 4'b0, 1'b1);
    chk("R1 busy_cycles clr", 32'(busy_cycles), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule